// File: doc/BRIEF.md
# Cartridge Disk Controller Register File

This block is the set of host-visible registers in front of a four-drive cartridge disk controller. The host reaches five 16-bit registers through a simple word/byte access port. The registers are a control/status word, a transfer bus address, a disk address, a multipurpose word backed by a three-entry queue, and a six-bit bus address extension. The extension register exists only when the block is built for the wider bus. Reads are combinational. Writes and read side effects take effect on the clock edge.

A write of the control/status word with its done bit clear launches a command. One cycle later the block pulses `cmd_start`, presenting the function code and the drive number. The command engine, which is outside this block, later reports completion on `cpl_valid` with error flags, sticky drive-error flags and an optional multipurpose load. A get-status command is finished inside the block. On its completion the block assembles a drive status word from per-drive sticky errors and drive condition inputs, and loads that word into all three queue entries. The interrupt request is a level that follows done and interrupt-enable as described below.

Top module: `dkc_regfile`

## Requirements
- R1: After reset, control/status reads 0x0080 plus the ready bit (bit 0). The bus address, disk address, extension and all queue entries read zero, `irq` is low and `cmd_start` is low.
- R2: The word index is `bus_addr[3:1]`: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Indexes 5 to 7 raise `bus_err` in the same cycle. Index 4 also raises `bus_err` when `EXT_PRESENT` is 0. An erroring read returns 0 and an erroring write changes nothing.
- R3: When `bus_byte` is set, the byte is carried in `bus_wdata[7:0]`. An odd `bus_addr[0]` replaces the register's high byte and keeps its low byte. An even address replaces the low byte and keeps the high byte.
- R4: The bus address register always reads bit 0 as 0. The disk address register holds all 16 bits.
- R5: The extension register holds `bus_wdata[5:0]`, and an odd-byte write to it is ignored. Its bits 1:0 and control/status bits 5:4 are the same storage, so a write to either register shows in both.
- R6: A control/status write whose resulting bit 7 (done) is 1 updates function (3:1), memory extension (5:4), interrupt enable (6), done (7) and drive (9:8). It starts nothing. It drops `irq` when the written enable is 0 and otherwise leaves `irq` unchanged.
- R7: A control/status write whose resulting bit 7 is 0 clears `irq` and error bits 14:10. In the next cycle it gives a one-cycle `cmd_start` with `cmd_func` equal to the written bits 3:1 and `cmd_drive` equal to the written bits 9:8.
- R8: Writing the multipurpose register loads all three queue entries. Reading it returns the head entry and shifts entry 2 to the head and entry 3 to entry 2, while entry 3 keeps its value.
- R9: `cpl_valid` sets done, sets `irq` to the interrupt-enable value and ORs `cpl_err` into bits 14:10. `irq` is never high while done is 0.
- R10: Bit 15 reads 1 exactly when any of bits 14:10 is 1. Writes affect only bits 9:1.
- R11: Bit 0 reads 1 when `drv_busy` of the drive named by bits 9:8 is 0.
- R12: On completion of function 2 (get status), all queue entries take the status word. The status word has bits 4:0 = 11101 if the drive is attached or bit 5 = 1 if it is not, bit 6 head, bit 7 double capacity, bits 11:9 sticky errors and bit 13 write lock. If disk address bit 3 is set, the drive's sticky errors are cleared before the word is built.
- R13: Completion of any other function ORs `cpl_sticky` into the sticky errors of `cmd_drive`. If `cpl_mp_wr` is set, that completion loads the queue head with `cpl_mp_data` and the other two entries with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte write (data in bits 7:0) |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| bus_err | output | 1 | Access to a missing register |
| drv_busy | input | 4 | Per-drive busy |
| drv_attached | input | 4 | Per-drive medium present |
| drv_dbl | input | 4 | Per-drive double capacity |
| drv_wlock | input | 4 | Per-drive write locked |
| drv_head | input | 4 | Per-drive selected head |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_func | output | 3 | Function of the last launch |
| cmd_drive | output | 2 | Drive of the last launch |
| cpl_valid | input | 1 | Command completion |
| cpl_err | input | 5 | Error flags for bits 14:10 |
| cpl_sticky | input | 3 | Sticky drive errors to set |
| cpl_mp_wr | input | 1 | Load queue head on completion |
| cpl_mp_data | input | 16 | Value for the queue head |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that a host access and `cpl_valid` never fall in the same cycle. The design does give completion priority if they do, but the ripple and mirror properties are written for separate events. They also assume that `cpl_valid` comes only while a command is outstanding. The random phase of the stimulus draws exactly one of write, read, completion or idle per cycle, so the first assumption always holds. Some completions in that phase arrive while no command is outstanding. This tests the done and interrupt rules under stray completions, and none of the properties depends on that assumption. The reference model follows the same one-event-per-cycle rule and is compared against outputs and read data on every cycle.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  localparam int WORD_W = 16;
  localparam int ERR_W  = 5;
  localparam int STK_W  = 3;

  // word indexes within the register window
  localparam logic [2:0] IDX_CS  = 3'd0;
  localparam logic [2:0] IDX_BA  = 3'd1;
  localparam logic [2:0] IDX_DA  = 3'd2;
  localparam logic [2:0] IDX_MP  = 3'd3;
  localparam logic [2:0] IDX_EXT = 3'd4;

  // control/status bit positions
  localparam int CS_RDY    = 0;
  localparam int CS_FN_LO  = 1;
  localparam int CS_MEX_LO = 4;
  localparam int CS_IE     = 6;
  localparam int CS_DONE   = 7;
  localparam int CS_DRV_LO = 8;
  localparam int CS_ERR_LO = 10;
  localparam int CS_SUM    = 15;

  // disk address bit that clears sticky errors on get status
  localparam int DA_CLR_STICKY = 3;

  typedef enum logic [2:0] {
    FN_NOP     = 3'd0,
    FN_WCHECK  = 3'd1,
    FN_GETSTAT = 3'd2,
    FN_SEEK    = 3'd3,
    FN_RDHDR   = 3'd4,
    FN_WRITE   = 3'd5,
    FN_READ    = 3'd6,
    FN_RDRAW   = 3'd7
  } dkc_fn_e;

  // apply a word or byte write on top of the current register value
  function automatic logic [WORD_W-1:0] merge_bytes(
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] wd,
      input logic              byte_mode,
      input logic              odd);
    if (!byte_mode) return wd;
    if (odd) return {wd[7:0], cur[7:0]};
    return {cur[15:8], wd[7:0]};
  endfunction

  // assemble the drive condition word reported by get status
  function automatic logic [WORD_W-1:0] drive_status_word(
      input logic [STK_W-1:0] sticky,
      input logic             head,
      input logic             att,
      input logic             dbl,
      input logic             wlk);
    logic [WORD_W-1:0] w;
    w = '0;
    if (att) w[4:0] = 5'b11101;
    else     w[5]   = 1'b1;
    w[6]     = head;
    w[7]     = dbl;
    w[11:9]  = sticky;
    w[13]    = wlk;
    return w;
  endfunction

endpackage

// File: rtl/dkc_mp_queue.sv
module dkc_mp_queue #(
  parameter int DEPTH = 3,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_all,
  input  logic         load_head,
  input  logic         pop,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] head,
  output logic [W-1:0] second
);

  localparam int SEC_IDX = (DEPTH > 1) ? 1 : 0;

  logic [W-1:0] ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (load_all) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= load_val;
    end else if (load_head) begin
      for (int i = 1; i < DEPTH; i++) ent[i] <= '0;
      ent[0] <= load_val;
    end else if (pop) begin
      // last entry keeps its value, the rest move one step toward the head
      for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
    end
  end

  assign head   = ent[0];
  assign second = ent[SEC_IDX];

endmodule

// File: rtl/dkc_drive_status.sv
module dkc_drive_status #(
  parameter int SEL_W = 2,
  parameter int STK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             set_en,
  input  logic [STK_W-1:0] set_bits,
  input  logic             clr_en,
  output logic [STK_W-1:0] sticky_sel
);

  localparam int N = 1 << SEL_W;

  logic [N*STK_W-1:0] sticky_vec;

  for (genvar d = 0; d < N; d++) begin : g_drv
    logic             hit;
    logic [STK_W-1:0] st_q;
    assign hit = (sel == SEL_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                st_q <= '0;
      else if (hit && clr_en)    st_q <= '0;
      else if (hit && set_en)    st_q <= st_q | set_bits;
    end
    assign sticky_vec[d*STK_W +: STK_W] = st_q;
  end

  assign sticky_sel = sticky_vec[int'(sel)*STK_W +: STK_W];

endmodule

// File: rtl/dkc_csr.sv
module dkc_csr
  import dkc_pkg::*;
#(
  parameter int DRV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [8:0]       wr_fields,   // merged write value bits 9:1
  input  logic             cpl_valid,
  input  logic [ERR_W-1:0] cpl_err,
  output logic [2:0]       fn_q,
  output logic             ie_q,
  output logic             done_q,
  output logic [DRV_W-1:0] drv_q,
  output logic [ERR_W-1:0] err_q,
  output logic             irq,
  output logic             cmd_start,
  output logic [2:0]       cmd_func,
  output logic [DRV_W-1:0] cmd_drive
);

  localparam int OFS = 1;  // wr_fields[0] is control/status bit 1

  logic [2:0]       w_fn;
  logic             w_ie;
  logic             w_done;
  logic [DRV_W-1:0] w_drv;

  assign w_fn   = wr_fields[CS_FN_LO-OFS +: 3];
  assign w_ie   = wr_fields[CS_IE-OFS];
  assign w_done = wr_fields[CS_DONE-OFS];
  assign w_drv  = wr_fields[CS_DRV_LO-OFS +: DRV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q      <= '0;
      ie_q      <= 1'b0;
      done_q    <= 1'b1;
      drv_q     <= '0;
      err_q     <= '0;
      irq       <= 1'b0;
      cmd_start <= 1'b0;
      cmd_func  <= '0;
      cmd_drive <= '0;
    end else begin
      cmd_start <= 1'b0;
      if (cpl_valid) begin
        done_q <= 1'b1;
        irq    <= ie_q;
        err_q  <= err_q | cpl_err;
      end else if (wr_en) begin
        fn_q   <= w_fn;
        ie_q   <= w_ie;
        done_q <= w_done;
        drv_q  <= w_drv;
        if (w_done) begin
          if (!w_ie) irq <= 1'b0;
        end else begin
          irq       <= 1'b0;
          err_q     <= '0;
          cmd_start <= 1'b1;
          cmd_func  <= w_fn;
          cmd_drive <= w_drv;
        end
      end
    end
  end

endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
  import dkc_pkg::*;
#(
  parameter int EXT_PRESENT = 1,
  parameter int EXT_W       = 6,
  parameter int MP_DEPTH    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_byte,
  input  logic [3:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_err,
  input  logic [3:0]           drv_busy,
  input  logic [3:0]           drv_attached,
  input  logic [3:0]           drv_dbl,
  input  logic [3:0]           drv_wlock,
  input  logic [3:0]           drv_head,
  output logic                 cmd_start,
  output logic [2:0]           cmd_func,
  output logic [1:0]           cmd_drive,
  input  logic                 cpl_valid,
  input  logic [ERR_W-1:0]     cpl_err,
  input  logic [STK_W-1:0]     cpl_sticky,
  input  logic                 cpl_mp_wr,
  input  logic [WORD_W-1:0]    cpl_mp_data,
  output logic                 irq
);

  localparam int DRV_W = 2;   // width of the drive field in control/status

  // ---------------- access decode ----------------
  logic [2:0] idx;
  logic       odd;
  logic       idx_ok;
  logic       acc_ok;

  assign idx = bus_addr[3:1];
  assign odd = bus_addr[0];

  if (EXT_PRESENT != 0) begin : g_ext_on
    assign idx_ok = (idx <= IDX_EXT);
  end else begin : g_ext_off
    assign idx_ok = (idx < IDX_EXT);
  end

  assign acc_ok  = bus_sel && idx_ok;
  assign bus_err = bus_sel && !idx_ok;

  logic host_wr, host_rd;
  assign host_wr = acc_ok && bus_wr && !cpl_valid;
  assign host_rd = acc_ok && !bus_wr;

  logic cs_wr_eff, ba_wr, da_wr, mp_wr, ext_wr_eff, mp_pop;
  assign cs_wr_eff  = host_wr && (idx == IDX_CS);
  assign ba_wr      = host_wr && (idx == IDX_BA);
  assign da_wr      = host_wr && (idx == IDX_DA);
  assign mp_wr      = host_wr && (idx == IDX_MP);
  assign ext_wr_eff = host_wr && (idx == IDX_EXT) && !(bus_byte && odd);
  assign mp_pop     = host_rd && (idx == IDX_MP) && !cpl_valid;

  // ---------------- storage ----------------
  logic [WORD_W-1:0] ba_q, da_q;
  logic [EXT_W-1:0]  ext_q;

  logic [2:0]       fn_q;
  logic             ie_q, done_q;
  logic [DRV_W-1:0] drv_q;
  logic [ERR_W-1:0] err_q;

  logic [WORD_W-1:0] mp_head, mp_second;

  // ---------------- read view ----------------
  logic [WORD_W-1:0] cs_view;
  logic [WORD_W-1:0] reg_view;

  always_comb begin
    cs_view = '0;
    cs_view[CS_RDY]                  = ~drv_busy[drv_q];
    cs_view[CS_FN_LO +: 3]           = fn_q;
    cs_view[CS_MEX_LO +: 2]          = ext_q[1:0];
    cs_view[CS_IE]                   = ie_q;
    cs_view[CS_DONE]                 = done_q;
    cs_view[CS_DRV_LO +: DRV_W]      = drv_q;
    cs_view[CS_ERR_LO +: ERR_W]      = err_q;
    cs_view[CS_SUM]                  = |err_q;
  end

  always_comb begin
    case (idx)
      IDX_CS:  reg_view = cs_view;
      IDX_BA:  reg_view = ba_q;
      IDX_DA:  reg_view = da_q;
      IDX_MP:  reg_view = mp_head;
      IDX_EXT: reg_view = WORD_W'(ext_q);
      default: reg_view = '0;
    endcase
  end

  assign bus_rdata = host_rd ? reg_view : '0;

  // ---------------- write merge ----------------
  logic [WORD_W-1:0] merged;
  logic              cs_wr_done;
  assign merged     = merge_bytes(reg_view, bus_wdata, bus_byte, odd);
  assign cs_wr_done = merged[CS_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q  <= '0;
      da_q  <= '0;
      ext_q <= '0;
    end else begin
      if (ba_wr) ba_q <= {merged[WORD_W-1:1], 1'b0};
      if (da_wr) da_q <= merged;
      if (ext_wr_eff)     ext_q      <= bus_wdata[EXT_W-1:0];
      else if (cs_wr_eff) ext_q[1:0] <= merged[CS_MEX_LO +: 2];
    end
  end

  // ---------------- control/status and command launch ----------------
  dkc_csr #(.DRV_W(DRV_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cs_wr_eff),
    .wr_fields (merged[9:1]),
    .cpl_valid (cpl_valid),
    .cpl_err   (cpl_err),
    .fn_q      (fn_q),
    .ie_q      (ie_q),
    .done_q    (done_q),
    .drv_q     (drv_q),
    .err_q     (err_q),
    .irq       (irq),
    .cmd_start (cmd_start),
    .cmd_func  (cmd_func),
    .cmd_drive (cmd_drive)
  );

  // ---------------- drive status and get-status completion ----------------
  logic             gs_cpl;
  logic             gs_clear;
  logic [STK_W-1:0] sticky_sel;
  logic [STK_W-1:0] sticky_eff;
  logic [WORD_W-1:0] stat_word;

  assign gs_cpl   = cpl_valid && (cmd_func == FN_GETSTAT);
  assign gs_clear = gs_cpl && da_q[DA_CLR_STICKY];

  dkc_drive_status #(.SEL_W(DRV_W), .STK_W(STK_W)) u_dstat (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (cmd_drive),
    .set_en     (cpl_valid && !gs_cpl),
    .set_bits   (cpl_sticky),
    .clr_en     (gs_clear),
    .sticky_sel (sticky_sel)
  );

  assign sticky_eff = da_q[DA_CLR_STICKY] ? '0 : sticky_sel;
  assign stat_word  = drive_status_word(sticky_eff, drv_head[cmd_drive],
                                        drv_attached[cmd_drive],
                                        drv_dbl[cmd_drive],
                                        drv_wlock[cmd_drive]);

  // ---------------- multipurpose queue ----------------
  logic              q_load_all, q_load_head;
  logic [WORD_W-1:0] q_val;

  assign q_load_all  = gs_cpl || mp_wr;
  assign q_load_head = cpl_valid && !gs_cpl && cpl_mp_wr;
  assign q_val       = gs_cpl ? stat_word : (cpl_valid ? cpl_mp_data : merged);

  dkc_mp_queue #(.DEPTH(MP_DEPTH), .W(WORD_W)) u_mpq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_all  (q_load_all),
    .load_head (q_load_head),
    .pop       (mp_pop),
    .load_val  (q_val),
    .head      (mp_head),
    .second    (mp_second)
  );

endmodule

// File: rtl/dkc_regfile_chk.sv
module dkc_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_wr_eff,
  input logic       cs_wr_done,
  input logic       cmd_start,
  input logic       irq,
  input logic       cpl_valid,
  input logic       ie_q,
  input logic       done_q,
  input logic [4:0] err_q,
  input logic       mp_pop,
  input logic [15:0] mp_head,
  input logic [15:0] mp_second,
  input logic       ext_wr_eff,
  input logic [1:0] ext_wdata,
  input logic [1:0] cs_mex
);

  AST_DONE_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr_eff && cs_wr_done |=> !cmd_start); // R6

  AST_GO_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr_eff && !cs_wr_done |=> cmd_start && !irq && (err_q == 5'd0)); // R7

  AST_CPL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> done_q && (irq == $past(ie_q))); // R9

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q); // R9

  AST_MP_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
    mp_pop |=> mp_head == $past(mp_second)); // R8

  AST_EXT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_eff |=> cs_mex == $past(ext_wdata)); // R5

endmodule

bind dkc_regfile dkc_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_wr_eff  (cs_wr_eff),
  .cs_wr_done (cs_wr_done),
  .cmd_start  (cmd_start),
  .irq        (irq),
  .cpl_valid  (cpl_valid),
  .ie_q       (ie_q),
  .done_q     (done_q),
  .err_q      (err_q),
  .mp_pop     (mp_pop),
  .mp_head    (mp_head),
  .mp_second  (mp_second),
  .ext_wr_eff (ext_wr_eff),
  .ext_wdata  (bus_wdata[1:0]),
  .cs_mex     (ext_q[1:0])
);

// File: tb/dkc_regfile_test.sv
`timescale 1ns/1ps
module dkc_regfile_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bus_sel = 0, bus_wr = 0, bus_byte = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata, rdata_n;
  logic        bus_err, err_n;
  logic [3:0]  drv_busy = 0, drv_attached = 0, drv_dbl = 0, drv_wlock = 0, drv_head = 0;
  logic        cmd_start, start_n;
  logic [2:0]  cmd_func, func_n;
  logic [1:0]  cmd_drive, drive_n;
  logic        cpl_valid = 0;
  logic [4:0]  cpl_err = 0;
  logic [2:0]  cpl_sticky = 0;
  logic        cpl_mp_wr = 0;
  logic [15:0] cpl_mp_data = 0;
  logic        irq, irq_n;

  dkc_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .drv_busy(drv_busy), .drv_attached(drv_attached), .drv_dbl(drv_dbl),
    .drv_wlock(drv_wlock), .drv_head(drv_head), .cmd_start(cmd_start),
    .cmd_func(cmd_func), .cmd_drive(cmd_drive), .cpl_valid(cpl_valid),
    .cpl_err(cpl_err), .cpl_sticky(cpl_sticky), .cpl_mp_wr(cpl_mp_wr),
    .cpl_mp_data(cpl_mp_data), .irq(irq));

  // narrow-bus build: extension register absent
  dkc_regfile #(.EXT_PRESENT(0)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .bus_err(err_n),
    .drv_busy(drv_busy), .drv_attached(drv_attached), .drv_dbl(drv_dbl),
    .drv_wlock(drv_wlock), .drv_head(drv_head), .cmd_start(start_n),
    .cmd_func(func_n), .cmd_drive(drive_n), .cpl_valid(cpl_valid),
    .cpl_err(cpl_err), .cpl_sticky(cpl_sticky), .cpl_mp_wr(cpl_mp_wr),
    .cpl_mp_data(cpl_mp_data), .irq(irq_n));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_fn, m_ie, m_done, m_drv, m_err, m_ext, m_ba, m_da, m_irq, m_start, m_cfn, m_cdrv;
  int mq[$];
  int m_sticky[4];

  function automatic void model_reset();
    m_fn = 0; m_ie = 0; m_done = 1; m_drv = 0; m_err = 0; m_ext = 0;
    m_ba = 0; m_da = 0; m_irq = 0; m_start = 0; m_cfn = 0; m_cdrv = 0;
    mq = {0, 0, 0};
    foreach (m_sticky[i]) m_sticky[i] = 0;
  endfunction

  function automatic int model_view(input int ix);
    case (ix)
      0: return (drv_busy[m_drv] ? 0 : 1) + m_fn * 2 + (m_ext % 4) * 16 + m_ie * 64
              + m_done * 128 + m_drv * 256 + m_err * 1024 + ((m_err != 0) ? 32768 : 0);
      1: return m_ba;
      2: return m_da;
      3: return mq[0];
      4: return m_ext;
      default: return 0;
    endcase
  endfunction

  function automatic int merge(input int cur, input int wd, input bit byt, input bit od);
    if (!byt) return wd;
    if (od) return (wd % 256) * 256 + cur % 256;
    return (cur / 256) * 256 + wd % 256;
  endfunction

  function automatic void model_step(input bit sel, input bit wr, input bit byt,
                                     input int addr, input int wd);
    int ix, v, w, st;
    bit od;
    ix = addr / 2; od = addr % 2;
    m_start = 0;
    if (cpl_valid) begin
      m_done = 1; m_irq = m_ie; m_err = m_err | cpl_err;
      if (m_cfn == 2) begin
        if ((m_da / 8) % 2 == 1) m_sticky[m_cdrv] = 0;
        st = m_sticky[m_cdrv];
        w = (drv_attached[m_cdrv] ? 29 : 32) + drv_head[m_cdrv] * 64 + drv_dbl[m_cdrv] * 128
            + st * 512 + drv_wlock[m_cdrv] * 8192;
        mq = {w, w, w};
      end else begin
        m_sticky[m_cdrv] = m_sticky[m_cdrv] | cpl_sticky;
        if (cpl_mp_wr) mq = {int'(cpl_mp_data), 0, 0};
      end
    end else if (sel && ix <= 4) begin
      if (!wr) begin
        if (ix == 3) begin
          void'(mq.pop_front());
          mq.push_back(mq[$]);
        end
      end else begin
        v = merge(model_view(ix), wd, byt, od);
        case (ix)
          0: begin
            m_fn = (v / 2) % 8; m_ext = (m_ext / 4) * 4 + (v / 16) % 4;
            m_ie = (v / 64) % 2; m_done = (v / 128) % 2; m_drv = (v / 256) % 4;
            if (m_done == 1) begin
              if (m_ie == 0) m_irq = 0;
            end else begin
              m_irq = 0; m_err = 0; m_start = 1; m_cfn = m_fn; m_cdrv = m_drv;
            end
          end
          1: m_ba = v - v % 2;
          2: m_da = v;
          3: mq = {v, v, v};
          default: if (!(byt && od)) m_ext = wd % 64;
        endcase
      end
    end
  endfunction

  // one clock of stimulus; called at a negative edge
  task automatic step(input bit sel, input bit wr, input bit byt, input int addr,
                      input int wd, input string tag);
    int ix;
    bus_sel = sel; bus_wr = wr; bus_byte = byt; bus_addr = 4'(addr); bus_wdata = 16'(wd);
    #1;
    ix = addr / 2;
    if (sel) begin
      chk("R2 bus_err", int'(bus_err), (ix > 4) ? 1 : 0);
      chk("R2 narrow bus_err", int'(err_n), (ix >= 4) ? 1 : 0);
    end
    if (sel && !wr) chk(tag, int'(bus_rdata), model_view(ix));
    model_step(sel, wr, byt, addr, wd);
    @(posedge clk); @(negedge clk);
    bus_sel = 0; cpl_valid = 0; cpl_mp_wr = 0;
    chk("R9 irq", int'(irq), m_irq);
    chk("R7 cmd_start", int'(cmd_start), m_start);
    if (m_start == 1) begin
      chk("R7 cmd_func", int'(cmd_func), m_cfn);
      chk("R7 cmd_drive", int'(cmd_drive), m_cdrv);
    end
  endtask

  task automatic wr_w(input int addr, input int d);
    step(1, 1, 0, addr, d, "");
  endtask
  task automatic wr_b(input int addr, input int d);
    step(1, 1, 1, addr, d, "");
  endtask
  task automatic rd(input int addr, input string tag);
    step(1, 0, 0, addr, 0, tag);
  endtask
  task automatic complete(input int e, input int s, input bit mw, input int md);
    cpl_valid = 1; cpl_err = 5'(e); cpl_sticky = 3'(s); cpl_mp_wr = mw; cpl_mp_data = 16'(md);
    step(0, 0, 0, 0, 0, "");
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 cmd_start", int'(cmd_start), 0);
    bus_sel = 1; bus_wr = 0; bus_addr = 0; #1;
    chk("R1 cs reset", int'(bus_rdata), 16'h0081);
    bus_sel = 0;
    for (int a = 2; a <= 8; a += 2) rd(a, "R1 reset reg");

    // R2 missing registers
    rd(10, "R2 read idx5"); rd(14, "R2 read idx7");
    wr_w(12, 16'hFFFF);
    rd(8, "R2 ext unaffected");
    // R4 bus address low bit, disk address full width
    wr_w(2, 16'h1235); rd(2, "R4 ba bit0");
    wr_w(4, 16'hFFFF); rd(4, "R4 da full");
    // R3 byte lanes
    wr_b(5, 16'h00AB); rd(4, "R3 odd byte");
    wr_b(4, 16'h00CD); rd(4, "R3 even byte");
    chk("R3 da value", int'(m_da), 16'hABCD);
    // R8 queue
    wr_w(6, 16'h1111);
    for (int k = 0; k < 4; k++) rd(6, "R8 mp ripple");
    wr_b(7, 16'h0022); rd(6, "R8 byte mp");
    // R6 done=1 write: fields, no start
    wr_w(0, 16'h02CC);   // drive 2, done, ie, mex 0, fn 6
    rd(0, "R6 cs fields");
    // R5 mirror both ways
    wr_w(8, 16'h002A); rd(0, "R5 mex from ext");
    wr_b(9, 16'h0033); rd(8, "R5 odd ignored");
    wr_w(0, 16'h02DC); rd(8, "R5 ext from cs");
    // R11 ready bit follows selected drive
    drv_busy = 4'b0100; rd(0, "R11 ready busy");
    drv_busy = 4'b0000; rd(0, "R11 ready idle");
    // R7 launch with ie set, R9 completion, R10 summary
    wr_w(0, 16'h024C); idle();
    complete(5'b00101, 3'b011, 0, 0); rd(0, "R10 err summary");
    wr_b(1, 16'h00FF); rd(0, "R10 high byte write");
    // R6 done=1 with ie 0 drops irq
    wr_w(0, 16'h0080); rd(0, "R6 ie clear");
    // R13 sticky on drive 1 via seek, then R12 get status with and without clear
    drv_attached = 4'b0010; drv_dbl = 4'b0010; drv_head = 4'b0010; drv_wlock = 4'b0010;
    wr_w(0, 16'h0106); complete(0, 3'b101, 0, 0);
    wr_w(4, 16'h0000); wr_w(0, 16'h0104); complete(0, 0, 0, 0);
    rd(6, "R12 status word sticky"); rd(6, "R12 status word e2");
    wr_w(4, 16'h0008); wr_w(0, 16'h0104); complete(0, 0, 0, 0);
    rd(6, "R12 status word cleared");
    wr_w(0, 16'h0004); complete(0, 0, 0, 0); rd(6, "R12 unattached drive 0");
    // R13 head-only load
    wr_w(0, 16'h0048); complete(0, 0, 1, 16'h5A5A);
    for (int k = 0; k < 3; k++) rd(6, "R13 head load");

    // random phase
    for (int c = 0; c < 3000; c++) begin
      int op;
      op = int'($urandom_range(0, 99));
      drv_busy = 4'($urandom); drv_attached = 4'($urandom); drv_dbl = 4'($urandom);
      drv_wlock = 4'($urandom); drv_head = 4'($urandom);
      if (op < 35) begin
        if ($urandom_range(0, 1) == 1) wr_b(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)));
        else wr_w(2 * int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)));
      end else if (op < 70) begin
        rd(2 * int'($urandom_range(0, 5)), "R8 R10 random read");
      end else if (op < 85) begin
        complete(int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)));
      end else begin
        idle();
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule